// File: doc/BRIEF.md
# Indirect-Addressed General-Purpose I/O Port

This block is a general-purpose I/O unit that a processor reaches through only two byte-wide locations. One location is an index register that chooses one of several internal registers; the other is a data window that reads or writes whichever internal register the index currently selects. The index is persistent, so software can select a register once and then access the data window as many times as it likes.

Internal registers come in pairs, one pair per group of pins: the data register sits at an even index and the direction register for the same pins at the following odd index. Two groups are built: a narrow 3-bit group at indices 0 and 1, and a full 8-bit group at indices 2 and 3. Each pin is modelled as a separate output value, output enable and input, so the tristate driver itself lives outside the block. Input pins are brought into the clock domain through a two-flop synchronizer before they can be read. Address decoding of the two locations on the CPU bus, and any protection against interrupts splitting an index/data sequence, are the job of the surrounding system.

Top module: `gpio_ix_port`

## Requirements
- R1: A write with `reg_sel`=0 loads `wr_data` into the index register; a read with `reg_sel`=0 returns the index; the index keeps its value until the next such write, so repeated data-window accesses reach the same register.
- R2: With `reg_sel`=1, index 0 is the narrow group's data register, 1 its direction register, 2 the wide group's data register and 3 its direction register; any index of 4 or more reads as 0 and a write through it changes no output.
- R3: A direction bit of 0 makes the pin an output (its `*_oe` bit is 1); a direction bit of 1 makes it an input (`*_oe` bit 0). The change appears on `*_oe` one clock after the write.
- R4: A data-register write is presented on the group's `*_out` vector one clock after the write, so every output pin drives the written value.
- R5: A data-register read returns, for input bits, the pin value after it has been stable for two rising edges (two-flop synchronizer), and for output bits the last value written.
- R6: A data value written while a pin is an input is driven at once, with no further data write, when that pin's direction bit is cleared to 0.
- R7: After reset the index is 0, every direction bit is 0 (all pins outputs) and every data bit is 0 (all outputs low).
- R8: In the narrow group, bits 7:3 of a data or direction read are 0 and bits 7:3 of a write are discarded.
- R9: A direction-register read returns the stored direction bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0 selects the index register, 1 the data window |
| wr_en | input | 1 | Write strobe for the selected location |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected location (combinational) |
| pin_a_in | input | 3 | Narrow group pin inputs |
| pin_a_out | output | 3 | Narrow group output values |
| pin_a_oe | output | 3 | Narrow group output enables (1 = drive) |
| pin_b_in | input | 8 | Wide group pin inputs |
| pin_b_out | output | 8 | Wide group output values |
| pin_b_oe | output | 8 | Wide group output enables (1 = drive) |

## Verification
A corrupted index shows up on the very next data-window access as a read of the wrong register, or a write landing on the wrong pins, one clock after the write. A bad data or direction bit is visible on `*_out` or `*_oe` in the cycle after the write that set it, and a stuck or skipped synchronizer stage shows up as a wrong input value read back two edges after a pin change. The bench models all four registers and the index, compares every read and every pin vector against that model after each operation, and mixes random traffic, including out-of-range indices, with directed direction-switching cases.

// File: rtl/gpio_ix_pkg.sv
package gpio_ix_pkg;

    localparam int BUS_W = 8;

    localparam logic [BUS_W-1:0] IX_A_DAT = 8'd0;
    localparam logic [BUS_W-1:0] IX_A_DIR = 8'd1;
    localparam logic [BUS_W-1:0] IX_B_DAT = 8'd2;
    localparam logic [BUS_W-1:0] IX_B_DIR = 8'd3;

endpackage

// File: rtl/gpio_ix_sync.sv
module gpio_ix_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_in;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stab;

endmodule

// File: rtl/gpio_ix_group.sv
module gpio_ix_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dat_we,
    input  logic         dir_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] dat_rd,
    output logic [W-1:0] dir_rd
);

    typedef struct packed {
        logic [W-1:0] dat;
        logic [W-1:0] dir;
    } grp_st_t;

    grp_st_t      st_d, st_q;
    logic [W-1:0] pin_s;

    gpio_ix_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_s)
    );

    always_comb begin
        st_d = st_q;
        if (dat_we) st_d.dat = wdata;
        if (dir_we) st_d.dir = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_out = st_q.dat;
    assign pin_oe  = ~st_q.dir;
    assign dat_rd  = (pin_s & st_q.dir) | (st_q.dat & ~st_q.dir);
    assign dir_rd  = st_q.dir;

    // R4: written data reaches the pins one clock later
    assert_out_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dat_we |=> (pin_out == $past(wdata)));

    // R6: without a data write the driven value survives any direction change
    assert_out_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_we |=> $stable(pin_out));

    // R3: direction write sets output enables to its inverse
    assert_dir_sets_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we |=> (pin_oe == ~$past(wdata)));

    // R5: output bits read back the driven value
    assert_rd_output_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((dat_rd ^ pin_out) & pin_oe) == '0);

endmodule

// File: rtl/gpio_ix_port.sv
module gpio_ix_port
    import gpio_ix_pkg::*;
#(
    parameter int A_W = 3,
    parameter int B_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wr_data,
    output logic [BUS_W-1:0] rd_data,
    input  logic [A_W-1:0]   pin_a_in,
    output logic [A_W-1:0]   pin_a_out,
    output logic [A_W-1:0]   pin_a_oe,
    input  logic [B_W-1:0]   pin_b_in,
    output logic [B_W-1:0]   pin_b_out,
    output logic [B_W-1:0]   pin_b_oe
);

    typedef struct packed {
        logic [BUS_W-1:0] idx;
    } top_st_t;

    top_st_t        st_d, st_q;
    logic           win_we;
    logic [A_W-1:0] a_dat_rd, a_dir_rd;
    logic [B_W-1:0] b_dat_rd, b_dir_rd;

    assign win_we = wr_en && reg_sel;

    always_comb begin
        st_d = st_q;
        if (wr_en && !reg_sel) st_d.idx = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    gpio_ix_group #(.W(A_W)) u_grp_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .dat_we  (win_we && (st_q.idx == IX_A_DAT)),
        .dir_we  (win_we && (st_q.idx == IX_A_DIR)),
        .wdata   (wr_data[A_W-1:0]),
        .pin_in  (pin_a_in),
        .pin_out (pin_a_out),
        .pin_oe  (pin_a_oe),
        .dat_rd  (a_dat_rd),
        .dir_rd  (a_dir_rd)
    );

    gpio_ix_group #(.W(B_W)) u_grp_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .dat_we  (win_we && (st_q.idx == IX_B_DAT)),
        .dir_we  (win_we && (st_q.idx == IX_B_DIR)),
        .wdata   (wr_data[B_W-1:0]),
        .pin_in  (pin_b_in),
        .pin_out (pin_b_out),
        .pin_oe  (pin_b_oe),
        .dat_rd  (b_dat_rd),
        .dir_rd  (b_dir_rd)
    );

    always_comb begin
        rd_data = '0;
        if (!reg_sel) begin
            rd_data = st_q.idx;
        end else begin
            case (st_q.idx)
                IX_A_DAT: rd_data = BUS_W'(a_dat_rd);
                IX_A_DIR: rd_data = BUS_W'(a_dir_rd);
                IX_B_DAT: rd_data = BUS_W'(b_dat_rd);
                IX_B_DIR: rd_data = BUS_W'(b_dir_rd);
                default:  rd_data = '0;
            endcase
        end
    end

    // R1: index loads on an index write
    assert_idx_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel) |=> (st_q.idx == $past(wr_data)));

    // R1: index persists otherwise
    assert_idx_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !reg_sel) |=> $stable(st_q.idx));

    // R2: writes through an unmapped index touch no pin
    assert_high_idx_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && (st_q.idx > IX_B_DIR)) |=>
            ($stable(pin_a_out) && $stable(pin_a_oe) && $stable(pin_b_out) && $stable(pin_b_oe)));

    // R8: narrow group upper read bits are zero
    assert_a_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && (st_q.idx <= IX_A_DIR)) |-> (rd_data[BUS_W-1:A_W] == '0));

endmodule

// File: tb/test_gpio_ix_port.sv
module test_gpio_ix_port;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_sel;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [2:0] pin_a_in, pin_a_out, pin_a_oe;
    logic [7:0] pin_b_in, pin_b_out, pin_b_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] m_idx;
    logic [2:0] m_adat, m_adir;
    logic [7:0] m_bdat, m_bdir;

    always #4 clk = ~clk;

    gpio_ix_port i_gpio_ix_port (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data),
        .pin_a_in(pin_a_in), .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe),
        .pin_b_in(pin_b_in), .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe)
    );

    function automatic logic [7:0] exp_win();
        case (m_idx)
            8'd0:    return {5'd0, (pin_a_in & m_adir) | (m_adat & ~m_adir)};
            8'd1:    return {5'd0, m_adir};
            8'd2:    return (pin_b_in & m_bdir) | (m_bdat & ~m_bdir);
            8'd3:    return m_bdir;
            default: return 8'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] v);
        @(negedge clk);
        reg_sel = sel; wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        if (!sel) m_idx = v;
        else case (m_idx)
            8'd0: m_adat = v[2:0];
            8'd1: m_adir = v[2:0];
            8'd2: m_bdat = v;
            8'd3: m_bdir = v;
            default: ;
        endcase
    endtask

    task automatic rd_check(input logic sel, input string req);
        @(negedge clk);
        reg_sel = sel; #1;
        check(req, rd_data, sel ? exp_win() : m_idx);
    endtask

    task automatic pins_check(input string req);
        #1;
        check({req, " a_out"}, {5'd0, pin_a_out}, {5'd0, m_adat});
        check({req, " a_oe"},  {5'd0, pin_a_oe},  {5'd0, ~m_adir});
        check({req, " b_out"}, pin_b_out, m_bdat);
        check({req, " b_oe"},  pin_b_oe,  ~m_bdir);
    endtask

    task automatic set_pins(input logic [2:0] a, input logic [7:0] b);
        @(negedge clk);
        pin_a_in = a; pin_b_in = b;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; reg_sel = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
        pin_a_in = 3'b000; pin_b_in = 8'h00;
        m_idx = 0; m_adat = 0; m_adir = 0; m_bdat = 0; m_bdir = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7 reset state
        rd_check(1'b0, "R7 index");
        pins_check("R7");
        for (int i = 0; i < 4; i++) begin
            wr(1'b0, 8'(i));
            rd_check(1'b1, "R7 register");
        end

        // R8 narrow group upper bits
        wr(1'b0, 8'd0); wr(1'b1, 8'hFF);
        rd_check(1'b1, "R8 data read");
        wr(1'b0, 8'd1); wr(1'b1, 8'hF8);
        rd_check(1'b1, "R8 dir read");
        pins_check("R8");

        // R6 input to output picks up stored value
        wr(1'b0, 8'd3); wr(1'b1, 8'hFF);
        pins_check("R3 all inputs");
        rd_check(1'b1, "R9 dir read");
        wr(1'b0, 8'd2); wr(1'b1, 8'hA5);
        pins_check("R4 written while input");
        set_pins(3'b010, 8'h3C);
        rd_check(1'b1, "R5 input read");
        wr(1'b0, 8'd3); wr(1'b1, 8'h0F);
        pins_check("R6 switched to output");
        wr(1'b0, 8'd2);
        rd_check(1'b1, "R6 mixed read");
        rd_check(1'b1, "R1 persistent index");

        // R2 unmapped index
        wr(1'b0, 8'd4); wr(1'b1, 8'hAA);
        rd_check(1'b1, "R2 idx4 read");
        pins_check("R2 idx4 write ignored");
        wr(1'b0, 8'hFF); wr(1'b1, 8'h55);
        rd_check(1'b1, "R2 idxFF read");
        rd_check(1'b0, "R1 index readback");
        pins_check("R2 idxFF write ignored");

        // random traffic
        for (int k = 0; k < 600; k++) begin
            int op;
            op = $urandom_range(0, 4);
            case (op)
                0: wr(1'b0, 8'($urandom_range(0, 5)));
                1: wr(1'b1, 8'($urandom));
                2: rd_check(1'b1, "R5 random read");
                3: set_pins(3'($urandom), 8'($urandom));
                default: rd_check(1'b0, "R1 random index");
            endcase
            pins_check("R4 random pins");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule